// File: doc/BRIEF.md
# NAND Cache-Program Sequencer

This block is the host side of a multi-page NAND write. Software or an upstream engine hands it a starting row address, a number of pages and a byte stream. It then writes the pages to consecutive rows of one die using cached programming. While the die moves one page into its array, the next page is already being loaded into the die's cache. Between pages the block polls the die's status byte. It turns the delayed cache-failure flag and the final failure flag into one pass/fail result per page, delivered in page order.

The NAND side is a simple one-cycle-per-strobe bus. `nand_we` marks a write cycle, qualified by `nand_cle` (command) or `nand_ale` (address); a write with neither is data. `nand_re` marks a status read, and `nand_dq_i` is sampled in that same cycle. Page data arrives on a valid/ready stream. A byte moves only when `in_valid` and `in_ready` are both high at a clock edge. When `in_valid` is low, no bus cycle is spent. Results leave on a second valid/ready stream. When the consumer holds `res_ready` low, the sequencer holds the result and stops all bus activity until the result is taken.

Top module: `nand_cache_prog`

## Requirements
- R1: During and after reset, `busy`, `done`, `err_timeout`, `res_valid`, `in_ready`, `nand_we`, `nand_re`, `nand_cle` and `nand_ale` are all low.
- R2: Each page k (0-based) is written in a fixed order:
  - command 80h;
  - COL_BYTES address bytes of zero;
  - ROW_BYTES address bytes of row start_row+k (modulo 2^(8*ROW_BYTES)), least significant byte first;
  - PAGE_BYTES data bytes;
  - command 15h, or command 10h for the last page.
- R3: `in_ready` is high only during the data phase. Every accepted byte appears on `nand_dq_o` as a data write in its acceptance cycle, in stream order. A cycle with `in_valid` low produces no bus write.
- R4: After each 15h or 10h, every poll is a status command followed by one read strobe.
  - When `dies_per_target` is 0 or 1, the status command is 70h.
  - When `dies_per_target` is 2 or more, it is 78h followed by the ROW_BYTES bytes of the current row, and 70h is never issued.
- R5: After a 15h, polling repeats until status bit 6 (cache ready) reads 1. The next 80h is issued only after that read.
- R6: On the ready read after the 15h of page k, with k ≥ 1, the block emits the result of page k-1. Its pass value is the inverse of status bit 1 (cache-program fail). For page 0 that bit is ignored.
- R7: After the 10h, polling repeats until status bit 5 (array ready) reads 1; bit 6 alone does not end this wait. The block then emits page N-2 from the inverse of bit 1 (only when N ≥ 2), followed by page N-1 from the inverse of bit 0.
- R8: Results appear on `res_valid`/`res_pass`/`res_page` with pages 0..N-1, each exactly once and in increasing order. While `res_valid` is high and `res_ready` is low, the result stays unchanged.
- R9: If MAX_POLLS consecutive reads in one wait lack the awaited ready bit, then:
  - `err_timeout` rises;
  - `busy` falls;
  - no further bus cycle is issued.
  
  The flag clears when the next run is accepted.
- R10: A `start` pulse while `busy` is high is ignored. A start with `page_count` of zero is also ignored.
- R11: `done` pulses for one cycle after the last result of a run is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| start_row | input | 8*ROW_BYTES | Row of the first page |
| page_count | input | CNT_W | Number of pages in the run |
| dies_per_target | input | DIE_W | Dies sharing the target; above 1 selects 78h polling |
| in_valid | input | 1 | Page byte valid |
| in_data | input | 8 | Page byte |
| in_ready | output | 1 | Sequencer accepts a page byte |
| res_valid | output | 1 | Page result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_page | output | CNT_W | Page index of the result |
| res_pass | output | 1 | 1 when the page programmed successfully |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at run completion |
| err_timeout | output | 1 | Status poll timed out |
| nand_cle | output | 1 | Command cycle qualifier |
| nand_ale | output | 1 | Address cycle qualifier |
| nand_we | output | 1 | Write strobe |
| nand_re | output | 1 | Status read strobe |
| nand_dq_o | output | 8 | Bus write byte |
| nand_dq_i | input | 8 | Bus read byte |

## Verification
The delicate case is a single final status read. It yields two results at once: the delayed cache-failure result for page N-2 and the final failure result for page N-1. These two results then meet result back-pressure. The bench sets the die model's fail flags per page at random and drops `res_ready` on random cycles. It judges the case by the page order, the pass values and the stability of each held result. A second collision is a `start` pulse that lands in the middle of a run. This is judged by the run's bus log and result count staying exactly those of the original request.

// File: rtl/nand_cprog_pkg.sv
package nand_cprog_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OPEN,
    S_ADDR,
    S_DATA,
    S_CLOSE,
    S_SCMD,
    S_SADDR,
    S_SREAD,
    S_EMIT_C,
    S_EMIT_F
  } ncp_state_e;

  localparam logic [7:0] OP_LOAD     = 8'h80;
  localparam logic [7:0] OP_CACHE    = 8'h15;
  localparam logic [7:0] OP_FINAL    = 8'h10;
  localparam logic [7:0] OP_STAT     = 8'h70;
  localparam logic [7:0] OP_STAT_DIE = 8'h78;

  localparam int BIT_RDY   = 6;
  localparam int BIT_ARDY  = 5;
  localparam int BIT_FAILC = 1;
  localparam int BIT_FAIL  = 0;

endpackage

// File: rtl/ncp_addr_sel.sv
module ncp_addr_sel #(
  parameter int COL_BYTES = 2,
  parameter int ROW_BYTES = 3,
  parameter int IW        = 3
) (
  input  logic [IW-1:0]          idx,
  input  logic                   skip_col,
  input  logic [8*ROW_BYTES-1:0] row,
  output logic [7:0]             byte_o
);
  always_comb begin
    byte_o = 8'h00;
    for (int r = 0; r < ROW_BYTES; r++) begin
      if (int'(idx) == (skip_col ? r : COL_BYTES + r)) byte_o = row[8*r +: 8];
    end
  end
endmodule

// File: rtl/ncp_poll_guard.sv
module ncp_poll_guard #(
  parameter int MAX_POLLS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic miss,
  output logic expired
);
  localparam int CW = $clog2(MAX_POLLS + 1);
  logic [CW-1:0] cnt;

  assign expired = miss && (cnt == CW'(MAX_POLLS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || expired) cnt <= '0;
    else if (miss)           cnt <= cnt + 1'b1;
  end

  assert_poll_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(MAX_POLLS));
  assert_expire_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> cnt == '0);
endmodule

// File: rtl/ncp_status_eval.sv
module ncp_status_eval
  import nand_cprog_pkg::*;
(
  input  logic [7:0] status,
  input  logic       final_wait,
  output logic       met,
  output logic       pass_cache,
  output logic       pass_final
);
  assign met        = final_wait ? status[BIT_ARDY] : status[BIT_RDY];
  assign pass_cache = !status[BIT_FAILC];
  assign pass_final = !status[BIT_FAIL];
endmodule

// File: rtl/nand_cache_prog.sv
module nand_cache_prog
  import nand_cprog_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int COL_BYTES  = 2,
  parameter int ROW_BYTES  = 3,
  parameter int CNT_W      = 8,
  parameter int DIE_W      = 2,
  parameter int MAX_POLLS  = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [8*ROW_BYTES-1:0] start_row,
  input  logic [CNT_W-1:0]       page_count,
  input  logic [DIE_W-1:0]       dies_per_target,
  input  logic                   in_valid,
  input  logic [7:0]             in_data,
  output logic                   in_ready,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [CNT_W-1:0]       res_page,
  output logic                   res_pass,
  output logic                   busy,
  output logic                   done,
  output logic                   err_timeout,
  output logic                   nand_cle,
  output logic                   nand_ale,
  output logic                   nand_we,
  output logic                   nand_re,
  output logic [7:0]             nand_dq_o,
  input  logic [7:0]             nand_dq_i
);
  localparam int ROW_W    = 8 * ROW_BYTES;
  localparam int ADDR_CYC = COL_BYTES + ROW_BYTES;
  localparam int AW       = $clog2(ADDR_CYC + 1);
  localparam int BW       = $clog2(PAGE_BYTES + 1);

  ncp_state_e       st;
  logic [CNT_W-1:0] page, npages;
  logic [ROW_W-1:0] row_base, row_cur;
  logic             multi_q;
  logic [AW-1:0]    acnt;
  logic [BW-1:0]    bcnt;
  logic             pass_c_q, pass_f_q;
  logic             last_pg, accept, abyte_last;
  logic [7:0]       abyte;
  logic             met, pc_now, pf_now, poll_miss, expired;

  assign row_cur    = row_base + ROW_W'(page);
  assign last_pg    = (page == npages - 1'b1);
  assign accept     = (st == S_IDLE) && start && (page_count != '0);
  assign abyte_last = (st == S_ADDR) ? (acnt == AW'(ADDR_CYC - 1))
                                     : (acnt == AW'(ROW_BYTES - 1));
  assign poll_miss  = (st == S_SREAD) && !met;

  ncp_addr_sel #(.COL_BYTES(COL_BYTES), .ROW_BYTES(ROW_BYTES), .IW(AW)) u_addr (
    .idx(acnt), .skip_col(st == S_SADDR), .row(row_cur), .byte_o(abyte));

  ncp_status_eval u_eval (
    .status(nand_dq_i), .final_wait(last_pg), .met(met),
    .pass_cache(pc_now), .pass_final(pf_now));

  ncp_poll_guard #(.MAX_POLLS(MAX_POLLS)) u_guard (
    .clk(clk), .rst_n(rst_n), .clear(st == S_CLOSE), .miss(poll_miss),
    .expired(expired));

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; page <= '0; npages <= '0; row_base <= '0; multi_q <= 1'b0;
      acnt <= '0; bcnt <= '0; pass_c_q <= 1'b0; pass_f_q <= 1'b0;
      done <= 1'b0; err_timeout <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          page <= '0; npages <= page_count; row_base <= start_row;
          multi_q <= (dies_per_target > DIE_W'(1)); err_timeout <= 1'b0;
          st <= S_OPEN;
        end
        S_OPEN: begin acnt <= '0; st <= S_ADDR; end
        S_ADDR: begin
          acnt <= acnt + 1'b1;
          if (abyte_last) begin bcnt <= '0; st <= S_DATA; end
        end
        S_DATA: if (in_valid) begin
          bcnt <= bcnt + 1'b1;
          if (bcnt == BW'(PAGE_BYTES - 1)) st <= S_CLOSE;
        end
        S_CLOSE: st <= S_SCMD;
        S_SCMD: begin
          acnt <= '0;
          st   <= multi_q ? S_SADDR : S_SREAD;
        end
        S_SADDR: begin
          acnt <= acnt + 1'b1;
          if (abyte_last) st <= S_SREAD;
        end
        S_SREAD: begin
          if (met) begin
            pass_c_q <= pc_now; pass_f_q <= pf_now;
            if (page != '0)   st <= S_EMIT_C;
            else if (last_pg) st <= S_EMIT_F;
            else begin page <= page + 1'b1; st <= S_OPEN; end
          end else if (expired) begin
            err_timeout <= 1'b1; st <= S_IDLE;
          end else begin
            st <= S_SCMD;
          end
        end
        S_EMIT_C: if (res_ready) begin
          if (last_pg) st <= S_EMIT_F;
          else begin page <= page + 1'b1; st <= S_OPEN; end
        end
        S_EMIT_F: if (res_ready) begin done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Bus and stream outputs
  always_comb begin
    nand_cle = 1'b0; nand_ale = 1'b0; nand_we = 1'b0; nand_re = 1'b0;
    nand_dq_o = 8'h00; in_ready = 1'b0;
    case (st)
      S_OPEN:  begin nand_we = 1'b1; nand_cle = 1'b1; nand_dq_o = OP_LOAD; end
      S_ADDR:  begin nand_we = 1'b1; nand_ale = 1'b1; nand_dq_o = abyte; end
      S_DATA:  begin in_ready = 1'b1; nand_we = in_valid; nand_dq_o = in_data; end
      S_CLOSE: begin nand_we = 1'b1; nand_cle = 1'b1;
                     nand_dq_o = last_pg ? OP_FINAL : OP_CACHE; end
      S_SCMD:  begin nand_we = 1'b1; nand_cle = 1'b1;
                     nand_dq_o = multi_q ? OP_STAT_DIE : OP_STAT; end
      S_SADDR: begin nand_we = 1'b1; nand_ale = 1'b1; nand_dq_o = abyte; end
      S_SREAD: nand_re = 1'b1;
      default: ;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign res_valid = (st == S_EMIT_C) || (st == S_EMIT_F);
  assign res_page  = (st == S_EMIT_C) ? page - 1'b1 : page;
  assign res_pass  = (st == S_EMIT_C) ? pass_c_q : pass_f_q;

  // Result order tracker for checking
  logic [CNT_W-1:0] exp_pg;
  always_ff @(posedge clk) begin
    if (!rst_n || accept)            exp_pg <= '0;
    else if (res_valid && res_ready) exp_pg <= exp_pg + 1'b1;
  end

  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_page) && $stable(res_pass));
  assert_res_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_page == exp_pg);
  assert_no_70_multi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    nand_we && nand_cle && multi_q |-> nand_dq_o != OP_STAT);
  assert_timeout_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> !busy && !nand_we && !nand_re);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/nand_cache_prog_test.sv
module nand_cache_prog_test;
  localparam int CLK_P = 10;
  localparam int PB    = 8;
  localparam int COLB  = 2;
  localparam int ROWB  = 3;
  localparam int MAXP  = 12;
  localparam int LOGN  = 4096;

  logic clk = 0, rst_n = 0, start = 0;
  logic [23:0] start_row = 0;
  logic [7:0]  page_count = 0;
  logic [1:0]  dies = 0;
  logic in_valid = 0, res_ready = 0;
  logic [7:0] in_data = 0, nand_dq_i = 0;
  logic in_ready, res_valid, res_pass, busy, done, err_timeout;
  logic [7:0] res_page, nand_dq_o;
  logic nand_cle, nand_ale, nand_we, nand_re;

  nand_cache_prog #(.PAGE_BYTES(PB), .COL_BYTES(COLB), .ROW_BYTES(ROWB),
    .CNT_W(8), .DIE_W(2), .MAX_POLLS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_row(start_row),
    .page_count(page_count), .dies_per_target(dies), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .res_valid(res_valid),
    .res_ready(res_ready), .res_page(res_page), .res_pass(res_pass),
    .busy(busy), .done(done), .err_timeout(err_timeout), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we(nand_we), .nand_re(nand_re),
    .nand_dq_o(nand_dq_o), .nand_dq_i(nand_dq_i));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int lg_kind [LOGN];
  int lg_val  [LOGN];
  int lg_n = 0;
  int nr [16];
  bit pf [16];
  int rs_page [16];
  bit rs_pass [16];
  int rs_n = 0, done_n = 0, hold_bad = 0;
  int run_id = 0, run_n = 0, stuck_pg = -1, cmd_cnt = 0, curk = 0, rem = 0;
  bit mode_final = 0, active = 0, pend = 0, pv = 0, pr = 0;
  int sidx = 0, bad [6];
  logic [7:0] ppage; logic ppass;

  function automatic logic [7:0] dbyte(int run, int k, int i);
    return 8'((run * 37 + k * 11 + i * 5 + 3) ^ (k << 4));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Stream drivers, result sink and die model
  always @(negedge clk) begin
    cyc++;
    if (active) begin
      if (pv && !pr) hold_bad += (!res_valid || res_page != ppage || res_pass != ppass) ? 1 : 0;
      res_ready = ($urandom % 3) != 0;
      if (res_valid && res_ready && rs_n < 16) begin
        rs_page[rs_n] = int'(res_page); rs_pass[rs_n] = res_pass; rs_n++;
      end
      pv = res_valid; pr = res_ready; ppage = res_page; ppass = res_pass;
      if (done) done_n++;
      if (pend) sidx++;
      if (sidx < run_n * PB && ($urandom % 4) != 0) begin
        in_valid = 1; in_data = dbyte(run_id, sidx / PB, sidx % PB);
      end else in_valid = 0;
      pend = in_valid && in_ready;
      #1;
      if ((nand_we || nand_re) && lg_n < LOGN) begin
        lg_kind[lg_n] = nand_re ? 3 : nand_cle ? 0 : nand_ale ? 1 : 2;
        lg_val[lg_n]  = nand_re ? 0 : int'(nand_dq_o);
        lg_n++;
      end
      if (nand_we && nand_cle && (nand_dq_o == 8'h15 || nand_dq_o == 8'h10)) begin
        curk = cmd_cnt; cmd_cnt++; rem = nr[curk & 15];
        mode_final = (nand_dq_o == 8'h10);
      end
      if (nand_re) begin
        if (rem > 0 || curk == stuck_pg) begin
          if (rem > 0) rem--;
          nand_dq_i = mode_final ? 8'h40 : 8'h00;
          nand_dq_i[1:0] = 2'($urandom);
        end else if (!mode_final) begin
          nand_dq_i = 8'h40;
          nand_dq_i[1] = (curk >= 1) ? pf[curk - 1] : 1'b1;
          nand_dq_i[0] = 1'($urandom);
        end else begin
          nand_dq_i = 8'h60;
          nand_dq_i[1] = (run_n >= 2) ? pf[run_n - 2] : 1'b1;
          nand_dq_i[0] = pf[run_n - 1];
        end
      end
    end
  end

  int p;
  task automatic expv(int kind, int val, int cat);
    if (p >= lg_n || lg_kind[p] != kind || lg_val[p] != val) bad[cat]++;
    p++;
  endtask

  task automatic run_seq(int n, int dn, logic [23:0] row, int stk, bit poke);
    int wait_c;
    run_id++; run_n = n; stuck_pg = stk; cmd_cnt = 0; curk = 0; rem = 0;
    lg_n = 0; rs_n = 0; done_n = 0; hold_bad = 0; sidx = 0; pend = 0;
    pv = 0; pr = 0; mode_final = 0;
    for (int k = 0; k < 16; k++) begin nr[k] = $urandom % 5; pf[k] = 1'($urandom); end
    for (int c = 0; c < 6; c++) bad[c] = 0;
    @(negedge clk);
    active = 1;
    start = 1; start_row = row; page_count = 8'(n); dies = 2'(dn);
    @(negedge clk);
    start = 0;
    wait_c = 0;
    while (!(done_n > 0 || (stk >= 0 && err_timeout && !busy)) && wait_c < 20000) begin
      @(negedge clk); wait_c++;
      if (poke && wait_c == 30) begin start = 1; page_count = 8'd1; start_row = ~row; end
      if (poke && wait_c == 31) start = 0;
    end
    repeat (4) @(negedge clk);
    active = 0; in_valid = 0; res_ready = 0;
    chk(wait_c < 20000, "R11", "run finished", wait_c, 20000);
    // Walk the bus log
    p = 0;
    for (int k = 0; k < n; k++) begin
      logic [23:0] r = row + 24'(k);
      int polls;
      expv(0, 8'h80, 0);
      for (int c = 0; c < COLB; c++) expv(1, 0, 0);
      for (int b = 0; b < ROWB; b++) expv(1, int'(r[8*b +: 8]), 0);
      for (int i = 0; i < PB; i++) expv(2, int'(dbyte(run_id, k, i)), 1);
      expv(0, (k == n - 1) ? 8'h10 : 8'h15, 0);
      polls = (k == stk) ? MAXP : nr[k] + 1;
      for (int q = 0; q < polls; q++) begin
        if (dn >= 2) begin
          expv(0, 8'h78, 2);
          for (int b = 0; b < ROWB; b++) expv(1, int'(r[8*b +: 8]), 2);
        end else expv(0, 8'h70, 2);
        expv(3, 0, 3);
      end
      if (k == stk) break;
    end
    chk(bad[0] == 0, "R2", "page framing mismatches", bad[0], 0);
    chk(bad[1] == 0, "R3", "data byte mismatches", bad[1], 0);
    chk(bad[2] == 0, "R4", "status command mismatches", bad[2], 0);
    chk(bad[3] == 0 && p == lg_n, "R5", "poll reads / log length", lg_n, p);
    chk(hold_bad == 0, "R8", "held result changed", hold_bad, 0);
    if (stk >= 0) begin
      chk(err_timeout && !busy, "R9", "timeout flag and stop", int'(err_timeout), 1);
      chk(rs_n == 0, "R9", "results after timeout", rs_n, 0);
    end else begin
      chk(rs_n == n, "R8", "result count", rs_n, n);
      for (int k = 0; k < rs_n && k < n; k++) begin
        chk(rs_page[k] == k, "R8", "result page order", rs_page[k], k);
        if (k == n - 1)
          chk(rs_pass[k] == !pf[k], "R7", "final page pass", int'(rs_pass[k]), int'(!pf[k]));
        else if (k == n - 2)
          chk(rs_pass[k] == !pf[k], "R7", "page N-2 pass", int'(rs_pass[k]), int'(!pf[k]));
        else
          chk(rs_pass[k] == !pf[k], "R6", "cached page pass", int'(rs_pass[k]), int'(!pf[k]));
      end
      chk(done_n == 1, "R11", "done pulses", done_n, 1);
      chk(!err_timeout, "R9", "flag clear on normal run", int'(err_timeout), 0);
      if (poke) chk(rs_n == n, "R10", "start while busy ignored", rs_n, n);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err_timeout && !res_valid && !in_ready &&
        !nand_we && !nand_re && !nand_cle && !nand_ale, "R1", "state in reset", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !res_valid && !in_ready && !nand_we && !nand_re, "R1",
        "state after reset", int'(busy), 0);
    // R10: zero page count gives no activity
    start = 1; page_count = 0; @(negedge clk); start = 0; @(negedge clk);
    chk(!busy && !nand_we, "R10", "zero-page start ignored", int'(busy), 0);
    run_seq(1, 1, 24'h000123, -1, 0);
    run_seq(2, 2, 24'h00A000, -1, 0);
    run_seq(4, 1, 24'hFFFFFE, -1, 1);
    run_seq(3, 3, 24'h123456, 1, 0);
    run_seq(3, 0, 24'h000010, -1, 0);
    for (int t = 0; t < 4; t++)
      run_seq(1 + int'($urandom % 6), int'($urandom % 4), 24'($urandom), -1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule